// File: doc/BRIEF.md
# Condition Test and Set Unit

This block takes the four integer condition flags (negative, zero, overflow, carry) and a 4-bit test selector and decides whether the chosen condition holds. One evaluator serves conditional branches, trap-on-condition and set-on-condition. Each accepted request gives one registered answer on the next clock edge.

For a branch caller, the always-false test has no meaning. The block marks that request as illegal when it returns the result. In set mode the block also drives an 8-bit fill value, all ones when the condition holds and all zeros when it does not, together with a one-cycle write strobe. Instruction decode, register or memory writeback and trap vectoring are handled by the caller.

Top module: `cond_eval`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `res_valid`, `res_illegal` and `set_we` are 0.
- R2: A request accepted on a rising edge with `req_valid`=1 produces exactly one cycle with `res_valid`=1, in the cycle after that edge. `res_valid` is 0 in every other cycle.
- R3: The single-flag tests use these selector codes: 4 carry clear (!C), 5 carry set (C), 6 not equal (!Z), 7 equal (Z), 8 overflow clear (!V), 9 overflow set (V), 10 plus (!N), 11 minus (N).
- R4: Selector 0 (true) always yields `res_true`=1 and selector 1 (false) always yields `res_true`=0, whatever the flags are.
- R5: The unsigned magnitude tests are selector 2 (higher, !C & !Z) and selector 3 (lower or same, C | Z).
- R6: The signed tests are selector 12 (greater or equal, N xnor V), 13 (less than, N xor V), 14 (greater than, !Z & (N xnor V)) and 15 (less or equal, Z | (N xor V)).
- R7: `res_illegal` is 1 in the result cycle exactly when the request had `req_branch`=1 and selector 1. It is 0 for every other request.
- R8: For a request with `req_set`=1, `set_we` is 1 in the result cycle and `set_data` is 8'hFF when the condition holds or 8'h00 when it does not.
- R9: For a request with `req_set`=0, `set_we` stays 0 in the result cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_branch | input | 1 | Caller is a conditional branch |
| req_set | input | 1 | Set-on-condition mode |
| sel | input | 4 | Condition selector |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| res_valid | output | 1 | Result strobe |
| res_true | output | 1 | Condition outcome |
| res_illegal | output | 1 | Always-false test requested by a branch |
| set_we | output | 1 | Set-mode write strobe |
| set_data | output | 8 | Fill byte for the set destination |

## Verification
The assertions compare each result with the inputs sampled one cycle earlier. They assume that those inputs are defined, meaning not X, on every edge where `req_valid` is 1. They also assume that nothing besides the request strobe decides whether a result appears. The stimulus meets both assumptions. It drives every input from the falling edge, holds each value through the next rising edge, and parks all request fields at known zeros between requests. It covers all 16 selectors against all 16 flag patterns, for each of the four combinations of branch and set. Requests arrive both back to back and with idle gaps.

// File: rtl/cond_eval.sv
module cond_eval #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_branch,
  input  logic              req_set,
  input  logic [3:0]        sel,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  output logic              res_valid,
  output logic              res_true,
  output logic              res_illegal,
  output logic              set_we,
  output logic [DATA_W-1:0] set_data
);

  localparam logic [3:0] SEL_F = 4'd1;

  logic hit;
  logic sgn_ge;

  assign sgn_ge = ~(flag_n ^ flag_v);

  always_comb begin
    unique case (sel)
      4'd0:    hit = 1'b1;
      4'd1:    hit = 1'b0;
      4'd2:    hit = ~flag_c & ~flag_z;
      4'd3:    hit = flag_c | flag_z;
      4'd4:    hit = ~flag_c;
      4'd5:    hit = flag_c;
      4'd6:    hit = ~flag_z;
      4'd7:    hit = flag_z;
      4'd8:    hit = ~flag_v;
      4'd9:    hit = flag_v;
      4'd10:   hit = ~flag_n;
      4'd11:   hit = flag_n;
      4'd12:   hit = sgn_ge;
      4'd13:   hit = ~sgn_ge;
      4'd14:   hit = ~flag_z & sgn_ge;
      default: hit = flag_z | ~sgn_ge;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_true    <= 1'b0;
      res_illegal <= 1'b0;
      set_we      <= 1'b0;
      set_data    <= '0;
    end else begin
      res_valid   <= req_valid;
      res_illegal <= req_valid & req_branch & (sel == SEL_F);
      set_we      <= req_valid & req_set;
      if (req_valid) res_true <= hit;
      if (req_valid & req_set) set_data <= {DATA_W{hit}};
    end
  end

  assert_result_follows_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid));
  assert_true_selector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(sel) == 4'd0) |-> res_true);
  assert_false_selector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(sel) == 4'd1) |-> !res_true);
  assert_illegal_only_on_false_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> (res_valid && !res_true && $past(req_branch)));
  assert_fill_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |-> (res_valid && set_data == {DATA_W{res_true}}));
  assert_no_strobe_without_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(req_set)) |-> !set_we);
  assert_signed_gt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(sel) == 4'd14) |->
      (res_true == (!$past(flag_z) && ($past(flag_n) == $past(flag_v)))));

endmodule

// File: tb/cond_eval_tb.sv
module cond_eval_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_branch = 1'b0, req_set = 1'b0;
  logic [3:0] sel = '0;
  logic flag_n = 0, flag_z = 0, flag_v = 0, flag_c = 0;
  logic res_valid, res_true, res_illegal, set_we;
  logic [7:0] set_data;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic       t;
    logic       ill;
    logic       we;
    logic [7:0] d;
    logic [3:0] sel;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  cond_eval u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_branch(req_branch),
    .req_set(req_set), .sel(sel), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c), .res_valid(res_valid), .res_true(res_true),
    .res_illegal(res_illegal), .set_we(set_we), .set_data(set_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic model(input logic [3:0] s, input logic n, z, v, c);
    case (s)
      0: return 1;           1: return 0;
      2: return !c && !z;    3: return c || z;
      4: return !c;          5: return c;
      6: return !z;          7: return z;
      8: return !v;          9: return v;
      10: return !n;         11: return n;
      12: return n == v;     13: return n != v;
      14: return !z && n == v;
      default: return z || n != v;
    endcase
  endfunction

  task automatic drive(input logic [3:0] s, input logic [3:0] f, input logic br, input logic st);
    exp_t e;
    @(negedge clk);
    req_valid = 1; sel = s; req_branch = br; req_set = st;
    {flag_n, flag_z, flag_v, flag_c} = f;
    e.t = model(s, f[3], f[2], f[1], f[0]);
    e.ill = br && s == 4'd1;
    e.we = st;
    e.d = {8{e.t}};
    e.sel = s;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_branch = 0; req_set = 0; sel = '0;
    {flag_n, flag_z, flag_v, flag_c} = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_valid) begin
        exp_t e;
        if (sb.size() == 0) begin
          check("R2 unexpected result", 1, 0);
        end else begin
          e = sb.pop_front();
          if (e.sel inside {0, 1}) check("R4 outcome", res_true, e.t);
          else if (e.sel inside {2, 3}) check("R5 outcome", res_true, e.t);
          else if (e.sel >= 12) check("R6 outcome", res_true, e.t);
          else check("R3 outcome", res_true, e.t);
          check("R7 illegal", res_illegal, e.ill);
          if (e.we) begin
            check("R8 strobe", set_we, 1);
            check("R8 fill", set_data, e.d);
          end else begin
            check("R9 no strobe", set_we, 0);
          end
        end
      end else begin
        check("R2 idle strobes", {res_illegal, set_we}, 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {res_valid, res_illegal, set_we}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {res_valid, res_illegal, set_we}, 0);
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 16; s++) begin
        for (int f = 0; f < 16; f++) begin
          drive(4'(s), 4'(f), m[0], m[1]);
          if ((s + f) % 5 == 0) idle();
        end
      end
    end
    idle();
    idle();
    idle();
    check("R2 all results seen", sb.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    compared++;
    mismatched++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule